// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block supervises a system from a free-running clock and produces its reset. It takes a digital supply-good flag from an external comparator, a push-button manual reset sense input (active low), and the data line of a two-wire serial bus. It drives a complementary pair of reset outputs and a flag that blocks writes to an attached non-volatile memory.

Every input is brought into the clock domain through a two-flop synchronizer. The supply flag then passes through a glitch filter, so a short dip cannot start a reset. The manual input passes through a longer debounce filter. A watchdog counts cycles without any transition on the bus data line, so ordinary bus traffic keeps the system alive without a dedicated kick pin. One shared timeout counter stretches every reset source to the same minimum length, and any new event restarts it. A build option removes the watchdog.

Top module: `supv_top`

## Requirements
- R1: After reset, and whenever the filtered supply flag is low, `rst_o` is 1 and `rst_no` is 0. A supply drop that lasts is seen on `rst_o` GLITCH_CYC+3 clock edges after `supply_ok_i` falls.
- R2: When `supply_ok_i` rises and stays high, `rst_o` returns to 0 exactly GLITCH_CYC+TIMEOUT_CYC+2 clock edges after the rise.
- R3: A low pulse on `supply_ok_i` shorter than GLITCH_CYC cycles changes neither `rst_o` nor `wr_inhibit_o`. A pulse of exactly GLITCH_CYC cycles asserts reset.
- R4: Holding `mrst_ni` low for at least DEBOUNCE_CYC cycles sets `rst_o` DEBOUNCE_CYC+3 edges after the press. A press shorter than DEBOUNCE_CYC cycles is ignored.
- R5: After `mrst_ni` returns high, `rst_o` clears DEBOUNCE_CYC+TIMEOUT_CYC+2 edges later.
- R6: With the watchdog built in, a data line that stays idle after a reset release asserts `rst_o` WDOG_CYC+1 edges after the release. That reset lasts exactly TIMEOUT_CYC cycles.
- R7: Any transition on `sda_i` restarts the watchdog, and the counter is held cleared while reset is asserted. After the last transition, reset follows WDOG_CYC+4 edges later. Transitions spaced no more than WDOG_CYC-2 cycles apart never let it expire.
- R8: A new reset event that arrives while the timeout is running restarts the timeout. Release then counts from the end of the newest event.
- R9: `wr_inhibit_o` is 1 from reset until the filtered supply flag is good. It falls GLITCH_CYC+2 edges after `supply_ok_i` rises, and rises GLITCH_CYC+2 edges after a lasting drop.
- R10: With WDOG_EN = 0, an idle data line never causes a reset.
- R11: `rst_no` is always the complement of `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's own flops |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, asynchronous |
| mrst_ni | input | 1 | Push-button manual reset, active low, asynchronous |
| sda_i | input | 1 | Two-wire bus data line, watched for activity |
| rst_o | output | 1 | System reset, active high |
| rst_no | output | 1 | System reset, active low |
| wr_inhibit_o | output | 1 | Blocks memory writes while the supply is not good |

## Verification
The assertions check the local rules on every cycle:
- a filtered supply fault or a debounced press is followed by reset;
- the inhibit flag never stays up without reset;
- a filter output moves only after a full run of disagreeing samples;
- the timeout restarts on every event and releases only from its last count;
- the watchdog counter clears on a kick or while reset is held, and fires for a single cycle.

The end-to-end latencies can be shown only by the bench scenarios. These include the exact release cycles, the accept and reject boundaries of the glitch and debounce lengths, the sweep of kick spacings, the restart of a running timeout by a manual press, and the absence of any watchdog reset in the build without one.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // bits for a counter holding 0..n-1
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter logic INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/supv_filter.sv
module supv_filter #(
  parameter int   LEN  = 4,
  parameter logic INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = supv_pkg::cnt_w(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          q_q;

  // output follows input only after LEN consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= INIT;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      q_q   <= d_i;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign q_o = q_q;

  assert_filter_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_q) |-> ($past(cnt_q) == LAST && $past(d_i) != $past(q_q)));

  assert_filter_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int PERIOD = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic hold_i,
  output logic fire_o
);
  localparam int CW = supv_pkg::cnt_w(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          sda_s, prev_q, kick;
  logic [CW-1:0] cnt_q;
  logic          fire_q;

  supv_sync #(.INIT(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sda_i),
    .q_o   (sda_s)
  );

  assign kick = sda_s ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      prev_q <= sda_s;
      if (hold_i || kick) begin
        cnt_q  <= '0;
        fire_q <= 1'b0;
      end else if (cnt_q == LAST) begin
        cnt_q  <= '0;
        fire_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + CW'(1);
        fire_q <= 1'b0;
      end
    end
  end

  assign fire_o = fire_q;

  assert_wd_hold_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0 && !fire_q));

  assert_wd_kick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> (cnt_q == '0 && !fire_q));

  assert_wd_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
endmodule

// File: rtl/supv_timeout.sv
module supv_timeout #(
  parameter int LEN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  output logic active_o
);
  localparam int CW = supv_pkg::cnt_w(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (event_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign active_o = active_q;

  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> (active_q && cnt_q == '0));

  assert_release_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(cnt_q) == LAST && !$past(event_i)));

  assert_idle_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> cnt_q == '0);
endmodule

// File: rtl/supv_top.sv
module supv_top #(
  parameter int GLITCH_CYC   = 5,
  parameter int DEBOUNCE_CYC = 1_000_000,
  parameter int TIMEOUT_CYC  = 10_000_000,
  parameter int WDOG_CYC     = 80_000_000,
  parameter bit WDOG_EN      = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic mrst_ni,
  input  logic sda_i,
  output logic rst_o,
  output logic rst_no,
  output logic wr_inhibit_o
);
  logic sup_s, mr_s, supply_good, mr_pressed, wd_fire, rst_event, active;

  supv_sync #(.INIT(1'b0)) u_sup_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(supply_ok_i), .q_o(sup_s)
  );

  supv_sync #(.INIT(1'b1)) u_mr_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(mrst_ni), .q_o(mr_s)
  );

  supv_filter #(.LEN(GLITCH_CYC), .INIT(1'b0)) u_sup_filt (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sup_s), .q_o(supply_good)
  );

  supv_filter #(.LEN(DEBOUNCE_CYC), .INIT(1'b0)) u_mr_filt (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(~mr_s), .q_o(mr_pressed)
  );

  generate
    if (WDOG_EN) begin : g_wdog
      supv_wdog #(.PERIOD(WDOG_CYC)) u_wdog (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sda_i (sda_i),
        .hold_i(active),
        .fire_o(wd_fire)
      );
    end else begin : g_no_wdog
      logic unused_sda;
      assign unused_sda = sda_i;
      assign wd_fire    = 1'b0;
    end
  endgenerate

  assign rst_event = ~supply_good | mr_pressed | wd_fire;

  supv_timeout #(.LEN(TIMEOUT_CYC)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (rst_event),
    .active_o(active)
  );

  assign rst_o        = active;
  assign rst_no       = ~active;
  assign wr_inhibit_o = ~supply_good;

  assert_supply_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_good |=> rst_o);

  assert_manual_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_pressed |=> rst_o);

  assert_inhibit_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_inhibit_o && $past(wr_inhibit_o)) |-> rst_o);

  assert_wdog_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fire |=> rst_o);
endmodule

// File: tb/sim_supv_top.sv
module sim_supv_top;
  localparam int G = 4;
  localparam int D = 6;
  localparam int T = 20;
  localparam int P = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic mrst_n = 1'b1;
  logic sda = 1'b1;
  logic rst_o, rst_no, inh;
  logic u1_rst, u1_rst_n, u1_inh;

  int checks = 0;
  int fails = 0;
  bit track_u1 = 1'b0;
  int u1_hits = 0;

  always #5 clk = ~clk;

  supv_top #(.GLITCH_CYC(G), .DEBOUNCE_CYC(D), .TIMEOUT_CYC(T), .WDOG_CYC(P), .WDOG_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .mrst_ni(mrst_n), .sda_i(sda),
    .rst_o(rst_o), .rst_no(rst_no), .wr_inhibit_o(inh)
  );

  supv_top #(.GLITCH_CYC(G), .DEBOUNCE_CYC(D), .TIMEOUT_CYC(T), .WDOG_CYC(P), .WDOG_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .mrst_ni(mrst_n), .sda_i(sda),
    .rst_o(u1_rst), .rst_no(u1_rst_n), .wr_inhibit_o(u1_inh)
  );

  always @(negedge clk) if (track_u1 && u1_rst) u1_hits++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // edges until rst_o == val, -1 if never
  task automatic count_until(input logic val, input int maxn, output int n);
    n = -1;
    for (int k = 1; k <= maxn; k++) begin
      @(posedge clk); #1;
      if (rst_o == val) begin
        n = k;
        break;
      end
    end
  endtask

  // mismatches of rst_o against val over cycles
  task automatic hold_rst(input logic val, input int cycles, output int bad);
    bad = 0;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk); #1;
      if (rst_o != val || rst_no != ~val) bad++;
    end
  endtask

  task automatic kick();
    @(negedge clk); sda = ~sda;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, n_inh, n_rst, bad;
    int gaps[5] = '{1, 2, 5, 100, P - 2};

    repeat (3) @(posedge clk); #1;
    chk("R1 reset state rst_o", int'(rst_o), 1);
    chk("R11 reset state rst_no", int'(rst_no), 0);
    chk("R9 reset state inhibit", int'(inh), 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (10) @(posedge clk); #1;
    chk("R1 supply low keeps reset", int'(rst_o), 1);

    // power-up release
    @(negedge clk) supply_ok = 1'b1;
    n_inh = -1; n_rst = -1;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk); #1;
      if (!inh && n_inh < 0) n_inh = k;
      if (!rst_o) begin n_rst = k; break; end
    end
    chk("R9 inhibit fall latency", n_inh, G + 2);
    chk("R2 power-up release latency", n_rst, G + T + 2);
    chk("R11 complement after release", int'(rst_no), 1);
    chk("R10 no-watchdog build releases too", int'(u1_rst), 0);

    // idle data line: watchdog expiry
    track_u1 = 1'b1;
    count_until(1'b1, P + 10, n);
    chk("R6 watchdog expiry latency", n, P + 1);
    chk("R11 complement during watchdog reset", int'(rst_no), 0);
    count_until(1'b0, T + 10, n);
    chk("R6 watchdog reset length", n, T);

    // kick spacing sweep
    bad = 0;
    foreach (gaps[i]) begin
      for (int r = 0; r < 3; r++) begin
        kick();
        for (int c = 0; c < gaps[i]; c++) begin
          @(posedge clk); #1;
          if (rst_o) bad++;
        end
      end
    end
    chk("R7 kicks keep reset low", bad, 0);
    kick();
    count_until(1'b1, P + 10, n);
    chk("R7 expiry after last data edge", n, P + 4);
    track_u1 = 1'b0;
    chk("R10 no watchdog reset without watchdog", u1_hits, 0);
    count_until(1'b0, T + 10, n);
    chk("R6 release after watchdog reset", n, T);

    // manual press shorter than debounce
    bad = 0;
    for (int w = 1; w < D; w++) begin
      kick();
      @(negedge clk) mrst_n = 1'b0;
      repeat (w) @(posedge clk);
      @(negedge clk) mrst_n = 1'b1;
      for (int c = 0; c < 2 * D + 6; c++) begin
        @(posedge clk); #1;
        if (rst_o) bad++;
      end
    end
    chk("R4 short presses ignored", bad, 0);

    // press of exactly D cycles
    kick();
    @(negedge clk) mrst_n = 1'b0;
    n = -1;
    for (int k = 1; k <= D + 10; k++) begin
      @(posedge clk); #1;
      if (rst_o && n < 0) n = k;
      if (k == D) @(negedge clk) mrst_n = 1'b1;
    end
    chk("R4 exact-length press latency", n, D + 3);
    count_until(1'b0, D + T + 20, n);
    chk("R4 exact press releases", int'(n > 0), 1);

    // long press
    kick();
    @(negedge clk) mrst_n = 1'b0;
    count_until(1'b1, D + 10, n);
    chk("R4 long press latency", n, D + 3);
    hold_rst(1'b1, 30, bad);
    chk("R4 reset held while pressed", bad, 0);
    @(negedge clk) mrst_n = 1'b1;
    count_until(1'b0, D + T + 10, n);
    chk("R5 release after button up", n, D + T + 2);

    // supply glitches below filter length
    bad = 0;
    for (int w = 1; w < G; w++) begin
      kick();
      @(negedge clk) supply_ok = 1'b0;
      repeat (w) @(posedge clk);
      @(negedge clk) supply_ok = 1'b1;
      for (int c = 0; c < 2 * G + 6; c++) begin
        @(posedge clk); #1;
        if (rst_o || inh) bad++;
      end
    end
    chk("R3 short supply glitches ignored", bad, 0);

    // glitch of exactly G cycles
    kick();
    @(negedge clk) supply_ok = 1'b0;
    n = -1;
    for (int k = 1; k <= G + 10; k++) begin
      @(posedge clk); #1;
      if (rst_o && n < 0) n = k;
      if (k == G) @(negedge clk) supply_ok = 1'b1;
    end
    chk("R3 exact-length glitch latency", n, G + 3);
    count_until(1'b0, G + T + 20, n);
    chk("R3 exact glitch releases", int'(n > 0), 1);

    // lasting drop
    kick();
    @(negedge clk) supply_ok = 1'b0;
    n_inh = -1; n_rst = -1;
    for (int k = 1; k <= G + 10; k++) begin
      @(posedge clk); #1;
      if (inh && n_inh < 0) n_inh = k;
      if (rst_o) begin n_rst = k; break; end
    end
    chk("R9 inhibit rise latency", n_inh, G + 2);
    chk("R1 brown-out reset latency", n_rst, G + 3);
    hold_rst(1'b1, 50, bad);
    chk("R1 reset held while supply low", bad, 0);
    chk("R9 inhibit held while supply low", int'(inh), 1);

    // press during running timeout restarts it
    @(negedge clk) supply_ok = 1'b1;
    repeat (G + 5) @(posedge clk); #1;
    chk("R8 still in timeout before press", int'(rst_o), 1);
    @(negedge clk) mrst_n = 1'b0;
    repeat (D + 2) @(posedge clk);
    @(negedge clk) mrst_n = 1'b1;
    count_until(1'b0, D + T + 20, n);
    chk("R8 release counted from newest event", n, D + T + 2);
    chk("R9 inhibit low after recovery", int'(inh), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule